// File: doc/BRIEF.md
# Double-Buffered SPI Master

This block is an 8-bit SPI master that sits on a zero-wait-state processor bus. It has one holding buffer and one shift register. Software writes a byte into the holding buffer. As soon as the shifter is idle, the buffer and the shift register swap their contents. That starts the new byte on the wire and leaves the byte received on the previous transfer in the buffer. While one byte shifts out, the next byte can already be waiting, so a driver keeps the link busy by polling or by servicing the interrupt.

Two flags report progress. The ready flag means the holding buffer can take a byte. The end flag means the buffer is empty and the shifter has stopped. Each flag has its own interrupt enable.

The SCLK rate can be fixed by a parameter or set through a divider register. The clock polarity and phase can also be fixed by a parameter or set through a control register. Slave selects are not generated by this block; general-purpose outputs drive them.

Top module: `spi_dbuf_master`

## Requirements
- R1: After reset, the status word reads 0x03 (TXR=1, TXE=1). Reset also sets the interrupt enables and `irq` to 0, and drives `sclk` to the CPOL level.
- R2: The bus uses a word index `bus_addr`: 0 is the shift register (read), 1 is the holding buffer (read/write), 2 is status on read and interrupt enables on write, 3 is the mode control (write), and 4 is the divider (write). Status bit 1 is TXR and bit 0 is TXE. A buffer write clears TXR. If the shifter is idle, the swap happens on the next cycle, and status then reads TXR=1, TXE=0 while the byte shifts.
- R3: A byte written while the shifter is busy stays pending with status 0x00 until the shifter finishes. The swap then happens on the first idle cycle.
- R4: Each swap puts the previously received byte in the buffer. When the last byte ends with nothing pending, status returns to 0x03 and the final received byte is readable at the shift register index.
- R5: Data is sent and received MSB first. The mode is 2 bits, with bit 1 = CPOL and bit 0 = CPHA. When CPHA=0, MISO is sampled on the leading edge and MOSI changes on the trailing edge. When CPHA=1, the edges are reversed.
- R6: When the divider is programmable, each SCLK half period lasts (divider+1) clock cycles, so SCLK = clk/((divider+1)*2).
- R7: While no byte is shifting, `sclk` rests at CPOL.
- R8: `irq` is (TXR and enable bit 1) or (TXE and enable bit 0), registered one cycle after the flags. With both enables at 0 it stays low.
- R9: When the fixed-divider parameter is nonzero, each half period is half that value in cycles, and writes to the divider index have no effect.
- R10: When the mode parameter is 0 to 3, that mode is used, and writes to the control index have no effect. Any other value makes the mode writable.
- R11: Read data is registered. It appears on the cycle after the request and holds while no read is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register word index |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| irq | output | 1 | Interrupt request |
| sclk | output | 1 | SPI serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The timing below counts from the clock edge that takes a bus write. The swap lands one edge later. A status read issued after the write's cycle therefore already sees the shifting state. Read data is due one edge after the request, and `irq` one edge after the flags change.

SCLK toggles every divider+1 cycles. The slave model in the bench counts the cycles between toggles within each byte. The bench drives and samples on falling edges only, so every sample falls after the register that produces it has updated.

// File: rtl/spi_dbuf_pkg.sv
package spi_dbuf_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [2:0] {
    IDX_SHIFT  = 3'd0,
    IDX_BUF    = 3'd1,
    IDX_STATUS = 3'd2,
    IDX_CTRL   = 3'd3,
    IDX_DIV    = 3'd4
  } reg_idx_e;
endpackage

// File: rtl/spi_dbuf_clkdiv.sv
module spi_dbuf_clkdiv #(
  parameter int DIV_W     = 4,
  parameter int FIXED_DIV = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  localparam int HALF = (FIXED_DIV != 0) ? FIXED_DIV / 2 : (1 << DIV_W);
  localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;

  logic [CW-1:0] cnt;
  logic [CW-1:0] lim;

  generate
    if (FIXED_DIV != 0) begin : g_fixed
      assign lim = CW'(FIXED_DIV / 2 - 1);
    end else begin : g_prog
      assign lim = div;
    end
  endgenerate

  assign tick = run && (cnt == lim);

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (tick)   cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/spi_dbuf_shifter.sv
module spi_dbuf_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] ld_data,
  input  logic         tick,
  input  logic         cpol,
  input  logic         cpha,
  input  logic         miso,
  output logic         busy,
  output logic         sclk,
  output logic         mosi,
  output logic [W-1:0] shreg
);
  localparam int EW = $clog2(2 * W);
  localparam logic [EW-1:0] LAST_EDGE = EW'(2 * W - 1);

  logic [EW-1:0] edge_n;
  logic          samp;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      sclk   <= cpol;
      mosi   <= 1'b0;
      shreg  <= '0;
      edge_n <= '0;
      samp   <= 1'b0;
    end else if (load) begin
      busy   <= 1'b1;
      sclk   <= cpol;
      shreg  <= ld_data;
      edge_n <= '0;
      if (!cpha) mosi <= ld_data[W-1];
    end else if (busy && tick) begin
      sclk   <= ~sclk;
      edge_n <= edge_n + 1'b1;
      if (!edge_n[0]) begin
        // leading edge
        if (cpha) mosi <= shreg[W-1];
        else      samp <= miso;
      end else begin
        // trailing edge
        if (cpha) begin
          shreg <= {shreg[W-2:0], miso};
        end else begin
          shreg <= {shreg[W-2:0], samp};
          mosi  <= shreg[W-2];
        end
        if (edge_n == LAST_EDGE) busy <= 1'b0;
      end
    end else if (!busy) begin
      sclk <= cpol;
    end
  end
endmodule

// File: rtl/spi_dbuf_master.sv
module spi_dbuf_master
  import spi_dbuf_pkg::*;
#(
  parameter int DIV_W     = 4,
  parameter int FIXED_DIV = 0,
  parameter int MODE_SEL  = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        bus_sel,
  input  logic        bus_we,
  input  logic [2:0]  bus_addr,
  input  logic [7:0]  bus_wdata,
  output logic [7:0]  bus_rdata,
  output logic        irq,
  output logic        sclk,
  output logic        mosi,
  input  logic        miso
);
  localparam int W = BYTE_W;

  logic             wr, rd, wr_buf, exch;
  logic [W-1:0]     buf_q;
  logic             buf_full;
  logic [1:0]       ien_q;
  logic [1:0]       mode_w;
  logic [DIV_W-1:0] div_w;
  logic             busy, tick, txr, txe;
  logic [W-1:0]     shreg;

  assign wr     = bus_sel && bus_we;
  assign rd     = bus_sel && !bus_we;
  assign wr_buf = wr && (bus_addr == IDX_BUF);
  assign exch   = buf_full && !busy && !wr_buf;
  assign txr    = !buf_full;
  assign txe    = !buf_full && !busy;

  generate
    if (MODE_SEL >= 0 && MODE_SEL < 4) begin : g_mode_fixed
      assign mode_w = 2'(MODE_SEL);
    end else begin : g_mode_prog
      logic [1:0] ctrl_q;
      always_ff @(posedge clk) begin
        if (rst) ctrl_q <= 2'b00;
        else if (wr && bus_addr == IDX_CTRL) ctrl_q <= bus_wdata[1:0];
      end
      assign mode_w = ctrl_q;
    end

    if (FIXED_DIV != 0) begin : g_div_fixed
      assign div_w = '0;
    end else begin : g_div_prog
      logic [DIV_W-1:0] div_q;
      always_ff @(posedge clk) begin
        if (rst) div_q <= '0;
        else if (wr && bus_addr == IDX_DIV) div_q <= bus_wdata[DIV_W-1:0];
      end
      assign div_w = div_q;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      buf_q    <= '0;
      buf_full <= 1'b0;
    end else if (wr_buf) begin
      buf_q    <= bus_wdata;
      buf_full <= 1'b1;
    end else if (exch) begin
      buf_q    <= shreg;
      buf_full <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) ien_q <= 2'b00;
    else if (wr && bus_addr == IDX_STATUS) ien_q <= bus_wdata[1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (rd) begin
      case (bus_addr)
        IDX_SHIFT:  bus_rdata <= shreg;
        IDX_BUF:    bus_rdata <= buf_q;
        IDX_STATUS: bus_rdata <= {6'b0, txr, txe};
        default:    bus_rdata <= '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= (txr & ien_q[1]) | (txe & ien_q[0]);
  end

  spi_dbuf_clkdiv #(.DIV_W(DIV_W), .FIXED_DIV(FIXED_DIV)) u_div (
    .clk (clk),
    .rst (rst),
    .run (busy),
    .div (div_w),
    .tick(tick)
  );

  spi_dbuf_shifter #(.W(W)) u_shf (
    .clk    (clk),
    .rst    (rst),
    .load   (exch),
    .ld_data(buf_q),
    .tick   (tick),
    .cpol   (mode_w[1]),
    .cpha   (mode_w[0]),
    .miso   (miso),
    .busy   (busy),
    .sclk   (sclk),
    .mosi   (mosi),
    .shreg  (shreg)
  );
endmodule

// File: rtl/spi_dbuf_chk.sv
module spi_dbuf_chk (
  input logic       clk,
  input logic       rst,
  input logic       wr_buf,
  input logic       buf_full,
  input logic       busy,
  input logic       sclk,
  input logic       cpol,
  input logic [1:0] ien,
  input logic       irq
);
  // R2: a buffer write leaves a pending byte (TXR low) after the edge
  assert_write_pends_R2: assert property (@(posedge clk) disable iff (rst)
    wr_buf |=> buf_full);

  // R3: a pending byte is never taken while the shifter is busy
  assert_hold_while_busy_R3: assert property (@(posedge clk) disable iff (rst)
    (busy && buf_full) |=> buf_full);

  // R4: starting a byte consumes the pending buffer
  assert_start_empties_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> (!buf_full && $past(buf_full)));

  // R7: idle clock level follows CPOL
  assert_sclk_idle_R7: assert property (@(posedge clk) disable iff (rst)
    (!busy && $past(!busy) && $stable(cpol)) |-> (sclk == cpol));

  // R8: masked interrupts keep irq low
  assert_irq_masked_R8: assert property (@(posedge clk) disable iff (rst)
    (ien == 2'b00) |=> !irq);
endmodule

bind spi_dbuf_master spi_dbuf_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .wr_buf  (wr_buf),
  .buf_full(buf_full),
  .busy    (busy),
  .sclk    (sclk),
  .cpol    (mode_w[1]),
  .ien     (ien_q),
  .irq     (irq)
);

// File: tb/sim_spi_dbuf_master.sv
module sim_spi_dbuf_master;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sel0 = 1'b0, sel1 = 1'b0, we = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata0, rdata1;
  logic       irq0, irq1, sclk0, sclk1, mosi0, mosi1;
  logic       miso0 = 1'b0;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_dbuf_master #(.DIV_W(4), .FIXED_DIV(0), .MODE_SEL(4)) u0 (
    .clk(clk), .rst(rst), .bus_sel(sel0), .bus_we(we), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata0), .irq(irq0), .sclk(sclk0),
    .mosi(mosi0), .miso(miso0));

  spi_dbuf_master #(.DIV_W(4), .FIXED_DIV(4), .MODE_SEL(1)) u1 (
    .clk(clk), .rst(rst), .bus_sel(sel1), .bus_we(we), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata1), .irq(irq1), .sclk(sclk1),
    .mosi(mosi1), .miso(mosi1));

  // ---------------- slave model for u0 ----------------
  logic       cur_cpol = 1'b0, cur_cpha = 1'b0;
  int         exp_half = 1;
  int         seed = 0;
  bit         slave_en = 0;
  logic [7:0] s_sh, s_rx;
  logic [7:0] rx_log [0:2];
  int         s_edges, s_idx, halfcnt;
  bit         halfbad;
  logic       sclk_prev = 1'b0;

  function automatic logic [7:0] sbyte(input int k);
    return 8'h3C ^ 8'(k * 8'h51) ^ 8'(seed * 7);
  endfunction

  function automatic logic [7:0] mbyte(input int k);
    return 8'hC3 + 8'(k * 37) + 8'(seed * 13);
  endfunction

  always @(negedge clk) begin
    if (!slave_en) begin
      s_idx = 0; s_edges = 0; halfcnt = 0; halfbad = 0; s_rx = '0;
      s_sh = sbyte(0);
      miso0 = cur_cpha ? 1'b0 : s_sh[7];
    end else begin
      halfcnt = halfcnt + 1;
      if (sclk0 != sclk_prev) begin
        if (s_edges != 0 && halfcnt != exp_half) halfbad = 1;
        halfcnt = 0;
        if (sclk0 != cur_cpol) begin // leading
          if (!cur_cpha) s_rx = {s_rx[6:0], mosi0};
          else begin miso0 = s_sh[7]; s_sh = {s_sh[6:0], 1'b0}; end
        end else begin               // trailing
          if (!cur_cpha) begin s_sh = {s_sh[6:0], 1'b0}; miso0 = s_sh[7]; end
          else s_rx = {s_rx[6:0], mosi0};
        end
        s_edges = s_edges + 1;
        if (s_edges == 16) begin
          if (s_idx < 3) rx_log[s_idx] = s_rx;
          s_idx = s_idx + 1;
          s_edges = 0;
          s_sh = sbyte(s_idx);
          if (!cur_cpha) miso0 = s_sh[7];
        end
      end
    end
    sclk_prev = sclk0;
  end

  // ---------------- helpers ----------------
  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input int t, input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    sel0 = (t == 0); sel1 = (t == 1); we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    sel0 = 1'b0; sel1 = 1'b0; we = 1'b0;
  endtask

  task automatic bus_rd(input int t, input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    sel0 = (t == 0); sel1 = (t == 1); we = 1'b0; addr = a;
    @(negedge clk);
    sel0 = 1'b0; sel1 = 1'b0;
    d = (t == 1) ? rdata1 : rdata0;
  endtask

  task automatic poll(input int t, input logic [7:0] mask);
    logic [7:0] d;
    for (int i = 0; i < 2000; i++) begin
      bus_rd(t, 3'd2, d);
      if ((d & mask) == mask) return;
    end
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // ---------------- main sequence ----------------
  initial begin
    logic [7:0] d;
    int n;
    logic p;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    bus_rd(0, 3'd2, d); check(d == 8'h03, "R1 status u0", d, 3);
    check(irq0 == 1'b0, "R1 irq u0", irq0, 0);
    check(sclk0 == 1'b0, "R1 sclk u0", sclk0, 0);
    bus_rd(1, 3'd2, d); check(d == 8'h03, "R1 status u1", d, 3);
    // R11: registered read holds with no request
    addr = 3'd1;
    @(negedge clk); check(rdata1 == 8'h03, "R11 read hold", rdata1, 3);

    for (int m = 0; m < 4; m++) begin
      for (int k = 0; k < 3; k++) begin
        int dv;
        dv = (k == 0) ? 0 : ((k == 1) ? 1 : 3);
        slave_en = 0;
        seed = m * 16 + dv;
        bus_wr(0, 3'd3, 8'(m));
        bus_wr(0, 3'd4, 8'(dv));
        cur_cpol = m[1]; cur_cpha = m[0]; exp_half = dv + 1;
        repeat (2) @(negedge clk);
        check(sclk0 == cur_cpol, "R7 idle level after mode write", sclk0, cur_cpol);
        slave_en = 1;
        @(negedge clk);

        bus_wr(0, 3'd1, mbyte(0));
        bus_rd(0, 3'd2, d); check(d == 8'h02, "R2 status while shifting", d, 2);
        bus_wr(0, 3'd1, mbyte(1));
        bus_rd(0, 3'd2, d); check(d == 8'h00, "R3 status with pending byte", d, 0);
        poll(0, 8'h02);
        bus_rd(0, 3'd1, d); check(d == sbyte(0), "R4 first received byte", d, sbyte(0));
        bus_wr(0, 3'd1, mbyte(2));
        poll(0, 8'h02);
        bus_rd(0, 3'd1, d); check(d == sbyte(1), "R4 second received byte", d, sbyte(1));
        poll(0, 8'h03);
        bus_rd(0, 3'd2, d); check(d == 8'h03, "R4 end status", d, 3);
        bus_rd(0, 3'd0, d); check(d == sbyte(2), "R4 last byte in shifter", d, sbyte(2));
        for (int b = 0; b < 3; b++)
          check(rx_log[b] == mbyte(b), "R5 slave received MSB-first byte", rx_log[b], mbyte(b));
        check(halfbad == 0, "R6 half period cycles", halfbad, 0);
        check(sclk0 == cur_cpol, "R7 idle level after burst", sclk0, cur_cpol);
      end
    end

    // R8 interrupt behaviour (u0 idle, mode 3, div 3)
    bus_wr(0, 3'd2, 8'h01);
    @(negedge clk); check(irq0 == 1'b1, "R8 TXE irq when idle", irq0, 1);
    bus_wr(0, 3'd1, 8'h5A);
    repeat (2) @(negedge clk); check(irq0 == 1'b0, "R8 TXE irq low while busy", irq0, 0);
    bus_wr(0, 3'd2, 8'h02);
    @(negedge clk); check(irq0 == 1'b1, "R8 TXR irq while busy", irq0, 1);
    poll(0, 8'h03);
    bus_wr(0, 3'd2, 8'h00);
    @(negedge clk); check(irq0 == 1'b0, "R8 irq masked", irq0, 0);

    // R9 / R10 fixed-configuration instance (mode 1, divide 4, MOSI looped to MISO)
    bus_wr(1, 3'd3, 8'h03);
    bus_wr(1, 3'd4, 8'h0F);
    repeat (2) @(negedge clk);
    check(sclk1 == 1'b0, "R10 control write ignored", sclk1, 0);
    bus_wr(1, 3'd1, 8'hA5);
    p = sclk1; n = 0;
    while (sclk1 == p && n < 100) begin @(negedge clk); n++; end
    p = sclk1; n = 0;
    while (sclk1 == p && n < 100) begin @(negedge clk); n++; end
    check(n == 2, "R9 fixed half period", n, 2);
    poll(1, 8'h03);
    bus_rd(1, 3'd0, d); check(d == 8'hA5, "R9 loopback byte mode 1", d, 8'hA5);
    check(sclk1 == 1'b0, "R10 idle level fixed mode", sclk1, 0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule